// File: doc/BRIEF.md
# Command and Completion FIFO Register Block

This block is the register-level face of a storage controller's simple queueing mode. A host hands the controller work by writing a command's bus address into a single request port. It collects finished work by reading a single reply port, and each read of that port takes one completion tag off a queue. Behind the request port sits a request FIFO, which the controller drains through a show-ahead pop port. Behind the reply port sits a reply FIFO, which the controller fills through a push port.

An interrupt status register reports whether completions are waiting. An interrupt mask register has inverted sense: a set bit blocks the interrupt and a clear bit lets it through. The parameter `IRQ_BIT` picks the bit position that both registers use. The default is bit 3, and a variant configuration uses bit 2. A scratchpad register reports firmware readiness. Reading it has no side effect, so the host can use it to flush posted writes.

Every access takes one bus cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `cmdq_regif`

## Requirements
- R1: A write to offset 0x40 pushes the 32-bit write data into the request FIFO. The controller side sees the entries in arrival order on `req_data_o` while `req_valid_o` is high, and each `req_pop_i` cycle removes the head entry.
- R2: A write to 0x40 while the request FIFO holds `DEPTH` entries is dropped and leaves the FIFO contents unchanged. It sets a sticky overflow flag, read at bit 0 of offset 0x30, which only reset clears.
- R3: A read of offset 0x44 while the reply FIFO is not empty returns the oldest completion tag on the next cycle and removes that tag. Tags come back in the order they were pushed.
- R4: A read of 0x44 while the reply FIFO is empty returns 0xFFFFFFFF and removes nothing. A tag pushed afterwards is returned by the next read.
- R5: Bit `IRQ_BIT` of offset 0x30 (bit 3 by default, bit 2 when `IRQ_BIT`=2) reads 1 exactly when the reply FIFO is not empty.
- R6: The mask register at offset 0x34 takes bit `IRQ_BIT` of a write. A 1 in that bit disables the interrupt and a 0 enables it. The register resets to the masked state and reads back the stored bit at that position, with 0 in all other bits.
- R7: `irq_o` is high exactly when the pending bit is set and the mask bit is clear.
- R8: Offset 0xB0 reads 0xFFFF0000 while `fw_ready_i` is high and 0 otherwise. Reading it changes no FIFO or flag.
- R9: Reads of any offset other than 0x30, 0x34, 0x44 and 0xB0, including the write-only 0x40, return 0. Writes to any offset other than 0x34 and 0x40 change nothing.
- R10: `cpl_full_o` is high while the reply FIFO holds `DEPTH` entries, and a completion pushed then is dropped.
- R11: After reset both FIFOs are empty, `req_valid_o` and `irq_o` are low, offset 0x30 reads 0 and offset 0x34 reads the mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after `reg_rd_i` |
| req_valid_o | output | 1 | Request FIFO not empty |
| req_data_o | output | 32 | Head of the request FIFO |
| req_pop_i | input | 1 | Remove the request head |
| cpl_push_i | input | 1 | Push a completion tag |
| cpl_tag_i | input | 32 | Completion tag |
| cpl_full_o | output | 1 | Reply FIFO full |
| fw_ready_i | input | 1 | Firmware ready indication |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the host issues at most one read and one write per cycle. They also assume the address is stable during the strobe cycle and that `IRQ_BIT` lies between 1 and 30, so the pending bit never collides with the overflow bit. The bench applies each strobe for exactly one cycle, changes inputs only on falling edges, and pops requests only while `req_valid_o` is high. A second instance built with `IRQ_BIT`=2 shares the same stimulus, which exercises the variant bit position.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_REQ     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_RPL     = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_SCRATCH = 8'hB0;

  localparam logic [DATA_W-1:0] FW_READY_WORD  = 32'hFFFF_0000;
  localparam logic [DATA_W-1:0] RPL_EMPTY_WORD = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_MASK, SEL_RPL, SEL_SCR
  } rd_sel_e;

  typedef struct packed {
    logic    req_push;
    logic    rpl_pop;
    logic    mask_wr;
    rd_sel_e rd_sel;
  } dec_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.rd_sel   = SEL_NONE;
    dec_o.req_push = wr_i && (addr_i == OFS_REQ);
    dec_o.mask_wr  = wr_i && (addr_i == OFS_MASK);
    dec_o.rpl_pop  = rd_i && (addr_i == OFS_RPL);
    if (rd_i) begin
      case (addr_i)
        OFS_STAT:    dec_o.rd_sel = SEL_STAT;
        OFS_MASK:    dec_o.rd_sel = SEL_MASK;
        OFS_RPL:     dec_o.rd_sel = SEL_RPL;
        OFS_SCRATCH: dec_o.rd_sel = SEL_SCR;
        default:     dec_o.rd_sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_regif.sv
module cmdq_regif
  import cmdq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int IRQ_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_valid_o,
  output logic [DATA_W-1:0] req_data_o,
  input  logic              req_pop_i,
  input  logic              cpl_push_i,
  input  logic [DATA_W-1:0] cpl_tag_i,
  output logic              cpl_full_o,
  input  logic              fw_ready_i,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  dec_t              dec;
  logic              req_empty, req_full;
  logic              rpl_empty;
  logic [DATA_W-1:0] rpl_head;
  logic [CW-1:0]     req_cnt, rpl_cnt;
  logic              mask_q, ovf_q, pending;
  logic [DATA_W-1:0] rdata_d;

  cmdq_decode u_dec (
    .wr_i  (reg_wr_i),
    .rd_i  (reg_rd_i),
    .addr_i(reg_addr_i),
    .dec_o (dec)
  );

  cmdq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_req_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (dec.req_push),
    .data_i (reg_wdata_i),
    .pop_i  (req_pop_i),
    .data_o (req_data_o),
    .empty_o(req_empty),
    .full_o (req_full),
    .count_o(req_cnt)
  );

  cmdq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rpl_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (cpl_push_i),
    .data_i (cpl_tag_i),
    .pop_i  (dec.rpl_pop),
    .data_o (rpl_head),
    .empty_o(rpl_empty),
    .full_o (cpl_full_o),
    .count_o(rpl_cnt)
  );

  assign req_valid_o = !req_empty;
  assign pending     = !rpl_empty;
  assign irq_o       = pending && !mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      if (dec.mask_wr) mask_q <= reg_wdata_i[IRQ_BIT];
      if (dec.req_push && req_full) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_d = '0;
    case (dec.rd_sel)
      SEL_STAT: begin
        rdata_d[IRQ_BIT] = pending;
        rdata_d[0]       = ovf_q;
      end
      SEL_MASK: rdata_d[IRQ_BIT] = mask_q;
      SEL_RPL:  rdata_d = rpl_empty ? RPL_EMPTY_WORD : rpl_head;
      SEL_SCR:  rdata_d = fw_ready_i ? FW_READY_WORD : '0;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rdata_d;
  end
endmodule

// File: rtl/cmdq_regif_chk.sv
module cmdq_regif_chk
  import cmdq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              fw_ready_i,
  input logic              irq_o,
  input logic              rpl_empty,
  input logic              req_full,
  input logic              mask_q,
  input logic              ovf_q
);
  logic mapped_rd;
  assign mapped_rd = (reg_addr_i == OFS_STAT) || (reg_addr_i == OFS_MASK) ||
                     (reg_addr_i == OFS_RPL)  || (reg_addr_i == OFS_SCRATCH);

  assert_req_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFS_REQ && req_full) |=> ovf_q);

  assert_ovf_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  assert_empty_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFS_RPL && rpl_empty) |=> (reg_rdata_o == RPL_EMPTY_WORD));

  assert_irq_needs_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !rpl_empty);

  assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !irq_o);

  assert_scratch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFS_SCRATCH && fw_ready_i) |=> (reg_rdata_o == FW_READY_WORD));

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !mapped_rd) |=> (reg_rdata_o == '0));
endmodule

bind cmdq_regif cmdq_regif_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .fw_ready_i (fw_ready_i),
  .irq_o      (irq_o),
  .rpl_empty  (rpl_empty),
  .req_full   (req_full),
  .mask_q     (mask_q),
  .ovf_q      (ovf_q)
);

// File: tb/cmdq_regif_bench.sv
module cmdq_regif_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_alt;
  logic        req_valid, req_valid_alt;
  logic [31:0] req_data, req_data_alt;
  logic        req_pop = 1'b0;
  logic        cpl_push = 1'b0;
  logic [31:0] cpl_tag = '0;
  logic        cpl_full, cpl_full_alt;
  logic        fw_ready = 1'b0;
  logic        irq, irq_alt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmdq_regif #(.DEPTH(DEPTH), .IRQ_BIT(3)) u_cmdq_regif (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .req_valid_o(req_valid), .req_data_o(req_data), .req_pop_i(req_pop),
    .cpl_push_i(cpl_push), .cpl_tag_i(cpl_tag), .cpl_full_o(cpl_full),
    .fw_ready_i(fw_ready), .irq_o(irq)
  );

  cmdq_regif #(.DEPTH(DEPTH), .IRQ_BIT(2)) u_cmdq_regif_alt (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_alt),
    .req_valid_o(req_valid_alt), .req_data_o(req_data_alt), .req_pop_i(req_pop),
    .cpl_push_i(cpl_push), .cpl_tag_i(cpl_tag), .cpl_full_o(cpl_full_alt),
    .fw_ready_i(fw_ready), .irq_o(irq_alt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_alt);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rdata; d_alt = rdata_alt;
  endtask

  task automatic cpl(input logic [31:0] t);
    @(negedge clk);
    cpl_push = 1'b1; cpl_tag = t;
    @(negedge clk);
    cpl_push = 1'b0;
  endtask

  task automatic pop_req(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'd0, req_valid}, 32'd1);
    check(req, req_data, exp);
    req_pop = 1'b1;
    @(negedge clk);
    req_pop = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d, da;
    check("R11 req_valid", {31'd0, req_valid}, 32'd0);
    check("R11 irq", {31'd0, irq}, 32'd0);
    bus_read(8'h30, d, da);
    check("R11 status", d, 32'h0);
    bus_read(8'h34, d, da);
    check("R11/R6 mask reset", d, 32'h8);
    check("R6 alt mask reset", da, 32'h4);
  endtask

  task automatic t_req_path;
    logic [31:0] d, da;
    bus_write(8'h40, 32'h1000_0040);
    bus_write(8'h40, 32'h2000_0080);
    bus_write(8'h40, 32'h3000_00C0);
    bus_read(8'h40, d, da);
    check("R9 read of request port", d, 32'h0);
    pop_req("R1 first", 32'h1000_0040);
    pop_req("R1 second", 32'h2000_0080);
    pop_req("R1 third", 32'h3000_00C0);
    check("R1 drained", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_req_overflow;
    logic [31:0] d, da;
    bus_read(8'h30, d, da);
    check("R2 no overflow yet", d, 32'h0);
    for (int i = 0; i < DEPTH; i++) bus_write(8'h40, 32'hA000_0000 + i);
    bus_write(8'h40, 32'hDEAD_BEEF);
    bus_read(8'h30, d, da);
    check("R2 overflow flag", d, 32'h1);
    for (int i = 0; i < DEPTH; i++) pop_req("R2 contents kept", 32'hA000_0000 + i);
    check("R2 dropped entry absent", {31'd0, req_valid}, 32'd0);
    bus_read(8'h30, d, da);
    check("R2 overflow sticky", d, 32'h1);
  endtask

  task automatic t_reply;
    logic [31:0] d, da;
    bus_read(8'h44, d, da);
    check("R4 empty read", d, 32'hFFFF_FFFF);
    cpl(32'h0000_0011);
    cpl(32'h0000_0022);
    @(negedge clk);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    bus_read(8'h30, d, da);
    check("R5 pending bit3", d, 32'h9);
    check("R5 alt pending bit2", da, 32'h5);
    bus_write(8'h34, 32'h0);
    @(negedge clk);
    check("R7 irq unmasked", {31'd0, irq}, 32'd1);
    check("R7 alt irq unmasked", {31'd0, irq_alt}, 32'd1);
    bus_read(8'h34, d, da);
    check("R6 mask readback", d, 32'h0);
    bus_write(8'h34, 32'h4);
    @(negedge clk);
    check("R6 alt masked by bit2", {31'd0, irq_alt}, 32'd0);
    check("R6 main ignores bit2", {31'd0, irq}, 32'd1);
    bus_write(8'h34, 32'h8);
    @(negedge clk);
    check("R6 main masked by bit3", {31'd0, irq}, 32'd0);
    check("R6 alt ignores bit3", {31'd0, irq_alt}, 32'd1);
    bus_write(8'h34, 32'h0);
    bus_read(8'h44, d, da);
    check("R3 first tag", d, 32'h11);
    bus_read(8'h44, d, da);
    check("R3 second tag", d, 32'h22);
    @(negedge clk);
    check("R7 irq drops when empty", {31'd0, irq}, 32'd0);
    bus_read(8'h44, d, da);
    check("R4 empty after drain", d, 32'hFFFF_FFFF);
    bus_read(8'h30, d, da);
    check("R5 pending clear", d, 32'h1);
    cpl(32'h0000_0033);
    bus_read(8'h44, d, da);
    check("R4 no phantom pop", d, 32'h33);
  endtask

  task automatic t_scratch;
    logic [31:0] d, da;
    fw_ready = 1'b0;
    bus_read(8'hB0, d, da);
    check("R8 not ready", d, 32'h0);
    fw_ready = 1'b1;
    cpl(32'h0000_0044);
    bus_read(8'hB0, d, da);
    check("R8 ready", d, 32'hFFFF_0000);
    bus_read(8'hB0, d, da);
    check("R8 ready repeat", d, 32'hFFFF_0000);
    bus_read(8'h44, d, da);
    check("R8 no side effect on reply", d, 32'h44);
  endtask

  task automatic t_unmapped;
    logic [31:0] d, da;
    bus_read(8'h3C, d, da);
    check("R9 unmapped read", d, 32'h0);
    bus_write(8'h44, 32'h5555_5555);
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_write(8'hB0, 32'h0);
    bus_write(8'h20, 32'h0);
    bus_read(8'h44, d, da);
    check("R9 reply unaffected", d, 32'hFFFF_FFFF);
    bus_read(8'h30, d, da);
    check("R9 status unaffected", d, 32'h1);
    bus_read(8'h34, d, da);
    check("R9 mask unaffected", d, 32'h0);
    check("R9 request unaffected", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_reply_full;
    logic [31:0] d, da;
    for (int i = 0; i < DEPTH; i++) cpl(32'hC000_0000 + i);
    @(negedge clk);
    check("R10 full flag", {31'd0, cpl_full}, 32'd1);
    cpl(32'hBAD0_BAD0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(8'h44, d, da);
      check("R10 kept tag", d, 32'hC000_0000 + i);
    end
    bus_read(8'h44, d, da);
    check("R10 dropped tag absent", d, 32'hFFFF_FFFF);
    check("R10 full cleared", {31'd0, cpl_full}, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_req_path;
    t_req_overflow;
    t_reply;
    t_scratch;
    t_unmapped;
    t_reply_full;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule